// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Reporting

This block turns a start/stop framed serial stream into parallel characters. The input is asynchronous, so it passes through a two-flop synchronizer first. The block then waits for a falling edge, checks the start bit at its middle, and samples each later bit at its centre. Sample timing comes from an external enable that pulses sixteen times per bit period. The frame format is set at run time: 7 or 8 data bits, either bit order, optional even or odd parity, and one or two stop bits.

Each accepted character is written to a one-entry holding register, and a ready flag is raised. Four status flags sit next to the holding register: framing error, parity error, overrun, and a summary flag that is the OR of those three. A read strobe empties the holding register and clears all four flags. Two policy inputs control what happens to unusual characters. The first decides whether a character with an error is stored (with its flags) or silently discarded. The second decides whether a break character is stored or dropped. A busy output is high while a character is being received.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rx_ready, err_frame, err_parity, err_overrun, err_any and busy are 0, and rd_data is 0.
- R2: A low level is taken as a start bit only if the synchronized input is still low at the eighth os_tick after the falling edge. If it is high there, the receiver returns to idle and stores nothing.
- R3: Data bits are received least significant first when cfg_msb_first=0 and most significant first when cfg_msb_first=1. With cfg_seven_bit=1, seven data bits are received and rd_data[7] reads 0. With cfg_seven_bit=0, eight bits are received.
- R4: With cfg_par_en=1, one parity bit follows the data. cfg_par_even=1 expects an even count of ones over data plus parity, and cfg_par_even=0 expects an odd count. A mismatch sets err_parity. With cfg_par_en=0, err_parity stays 0.
- R5: A stored character whose stop bit was sampled low sets err_frame.
- R6: Storing a character while rx_ready is still 1 sets err_overrun, and rd_data takes the new character.
- R7: err_any is 1 exactly when at least one of err_frame, err_parity or err_overrun is 1.
- R8: A one-cycle rd_strobe, with no character arriving in that cycle, clears rx_ready, err_frame, err_parity, err_overrun and err_any on the next clock.
- R9: A non-break character with a framing or parity error is stored and flagged when cfg_err_accept=1. When cfg_err_accept=0 it is discarded, and the holding register and all flags stay unchanged.
- R10: A break is a frame in which every data bit, the parity bit (if enabled) and every stop bit is sampled 0. With cfg_brk_accept=0 it is dropped without any change. With cfg_brk_accept=1 it is stored as data 0 with err_frame set, whatever cfg_err_accept is.
- R11: busy is 1 from the accepted start edge until the final stop-bit sample.
- R12: With cfg_two_stop=1, two stop bits are sampled, and a low level in either one sets err_frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial input, idles high |
| os_tick | input | 1 | Enable pulsing 16 times per bit period |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_msb_first | input | 1 | 1 = most significant bit first |
| cfg_seven_bit | input | 1 | 1 = seven data bits, 0 = eight |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_err_accept | input | 1 | 1 = store characters that have errors |
| cfg_brk_accept | input | 1 | 1 = store break characters |
| rd_strobe | input | 1 | Reads the holding register and clears the flags |
| rd_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | A character is waiting to be read |
| err_frame | output | 1 | Stop bit sampled low |
| err_parity | output | 1 | Parity mismatch |
| err_overrun | output | 1 | Character overwritten before it was read |
| err_any | output | 1 | OR of the three error flags |
| busy | output | 1 | Reception in progress |

## Verification
The assertions assume that the format and policy inputs do not change while a frame is being received. They also assume that rd_strobe is a single-cycle pulse, and that os_tick is a sparse enable and not a level held high. The stimulus changes configuration only when the line is idle and the receiver has finished. It pulses the read strobe for exactly one clock. It drives os_tick once every four clocks, so each bit lasts sixty-four clocks and the mid-bit samples fall well inside the bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic frame;
        logic parity;
        logic overrun;
    } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_msb_first,
    input  logic              cfg_seven_bit,
    input  logic              cfg_two_stop,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] ch_data,
    output logic              ch_fe,
    output logic              ch_pe,
    output logic              ch_brk
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OS_RATE - 1);
    localparam logic [BIT_W-1:0] LAST_FULL  = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(DATA_W - 2);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sh;
        logic              acc;
        logic              ones;
        logic              stop2;
        logic              fe;
        logic              pe;
        logic              prev;
        logic              done;
        logic              brk;
        logic [DATA_W-1:0] dout;
    } fr_t;

    fr_t r_d, r_q;
    logic [BIT_W-1:0] last_bit;
    logic             fin_fe, fin_ones, at_end;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.prev = rx_s;
        last_bit = cfg_seven_bit ? LAST_SHORT : LAST_FULL;
        fin_fe   = r_q.fe | ~rx_s;
        fin_ones = r_q.ones | rx_s;
        at_end   = tick && (r_q.cnt == LAST_CNT);
        if (tick && !at_end && r_q.st != ST_IDLE && r_q.st != ST_START) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (r_q.prev && !rx_s) begin
                    r_d.st  = ST_START;
                    r_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (r_q.cnt == MID_CNT) begin
                        if (!rx_s) begin
                            r_d.st    = ST_DATA;
                            r_d.cnt   = '0;
                            r_d.bitn  = '0;
                            r_d.sh    = '0;
                            r_d.acc   = 1'b0;
                            r_d.ones  = 1'b0;
                            r_d.stop2 = 1'b0;
                            r_d.fe    = 1'b0;
                            r_d.pe    = 1'b0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (at_end) begin
                    r_d.cnt  = '0;
                    r_d.sh   = cfg_msb_first ? {r_q.sh[DATA_W-2:0], rx_s}
                                             : {rx_s, r_q.sh[DATA_W-1:1]};
                    r_d.acc  = r_q.acc ^ rx_s;
                    r_d.ones = fin_ones;
                    if (r_q.bitn == last_bit) begin
                        r_d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    end else begin
                        r_d.bitn = r_q.bitn + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (at_end) begin
                    r_d.cnt  = '0;
                    r_d.pe   = (r_q.acc ^ rx_s) ^ ~cfg_par_even;
                    r_d.ones = fin_ones;
                    r_d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (at_end) begin
                    r_d.cnt  = '0;
                    r_d.fe   = fin_fe;
                    r_d.ones = fin_ones;
                    if (cfg_two_stop && !r_q.stop2) begin
                        r_d.stop2 = 1'b1;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.brk  = ~fin_ones;
                        r_d.dout = (cfg_seven_bit && !cfg_msb_first) ? (r_q.sh >> 1) : r_q.sh;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign ch_data = r_q.dout;
    assign ch_fe   = r_q.fe;
    assign ch_pe   = r_q.pe;
    assign ch_brk  = r_q.brk;

    p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_START && tick && r_q.cnt == MID_CNT && rx_s) |=> (!busy && !done));

    p_par_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_par_en) |-> !ch_pe);

    p_brk_fe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ch_brk) |-> ch_fe);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] ch_data,
    input  logic              ch_fe,
    input  logic              ch_pe,
    input  logic              ch_brk,
    input  logic              cfg_err_accept,
    input  logic              cfg_brk_accept,
    input  logic              rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              fe,
    output logic              pe,
    output logic              oe,
    output logic              any
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        rx_flags_t         fl;
        logic              any;
    } st_t;

    st_t s_d, s_q;
    logic store;

    always_comb begin
        if (ch_brk)              store = done && cfg_brk_accept;
        else if (ch_fe || ch_pe) store = done && cfg_err_accept;
        else                     store = done;

        s_d = s_q;
        if (rd) begin
            s_d.ready = 1'b0;
            s_d.fl    = '0;
        end
        if (store) begin
            s_d.data       = ch_data;
            s_d.ready      = 1'b1;
            s_d.fl.frame   = s_d.fl.frame | ch_fe;
            s_d.fl.parity  = s_d.fl.parity | ch_pe;
            s_d.fl.overrun = s_d.fl.overrun | (s_q.ready && !rd);
        end
        s_d.any = s_d.fl.frame | s_d.fl.parity | s_d.fl.overrun;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.data;
    assign ready   = s_q.ready;
    assign fe      = s_q.fl.frame;
    assign pe      = s_q.fl.parity;
    assign oe      = s_q.fl.overrun;
    assign any     = s_q.any;

    p_any_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any == (fe | pe | oe));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!ready && !any));

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store && ready && !rd) |=> oe);

    p_err_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ch_brk && (ch_fe || ch_pe) && !cfg_err_accept && !rd)
            |=> ($stable(ready) && $stable(rd_data) && $stable(any)));

    p_brk_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ch_brk && !cfg_brk_accept && !rd) |=> ($stable(ready) && $stable(any)));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
    parameter int OS_RATE     = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              os_tick,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_msb_first,
    input  logic              cfg_seven_bit,
    input  logic              cfg_two_stop,
    input  logic              cfg_err_accept,
    input  logic              cfg_brk_accept,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_ready,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun,
    output logic              err_any,
    output logic              busy
);
    logic              rx_s;
    logic              done;
    logic [DATA_W-1:0] ch_data;
    logic              ch_fe, ch_pe, ch_brk;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    uart_rx_frame #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) i_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_s         (rx_s),
        .tick         (os_tick),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .cfg_msb_first(cfg_msb_first),
        .cfg_seven_bit(cfg_seven_bit),
        .cfg_two_stop (cfg_two_stop),
        .busy         (busy),
        .done         (done),
        .ch_data      (ch_data),
        .ch_fe        (ch_fe),
        .ch_pe        (ch_pe),
        .ch_brk       (ch_brk)
    );

    uart_rx_status #(.DATA_W(DATA_W)) i_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .done          (done),
        .ch_data       (ch_data),
        .ch_fe         (ch_fe),
        .ch_pe         (ch_pe),
        .ch_brk        (ch_brk),
        .cfg_err_accept(cfg_err_accept),
        .cfg_brk_accept(cfg_brk_accept),
        .rd            (rd_strobe),
        .rd_data       (rd_data),
        .ready         (rx_ready),
        .fe            (err_frame),
        .pe            (err_parity),
        .oe            (err_overrun),
        .any           (err_any)
    );
endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;
    localparam int DIV = 4;
    localparam int BITCLK = 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b1;
    logic os_tick = 1'b0;
    logic cfg_par_en = 0, cfg_par_even = 0, cfg_msb_first = 0, cfg_seven_bit = 0;
    logic cfg_two_stop = 0, cfg_err_accept = 0, cfg_brk_accept = 0;
    logic rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic rx_ready, err_frame, err_parity, err_overrun, err_any, busy;

    int total = 0;
    int bad = 0;
    bit quiet = 0;
    bit ended = 0;
    string cur_req = "R1";

    logic [7:0] m_data = '0;
    logic m_ready = 0, m_fe = 0, m_pe = 0, m_oe = 0;

    uart_rx_core i_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_msb_first(cfg_msb_first), .cfg_seven_bit(cfg_seven_bit),
        .cfg_two_stop(cfg_two_stop), .cfg_err_accept(cfg_err_accept),
        .cfg_brk_accept(cfg_brk_accept), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun),
        .err_any(err_any), .busy(busy)
    );

    always #10 clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % DIV;
            os_tick = (tc == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model compared on every clock while no frame or read is in flight
    always @(negedge clk) begin
        if (quiet && !ended) begin
            chk(cur_req,
                {rd_data, rx_ready, err_frame, err_parity, err_overrun, err_any, busy},
                {m_data, m_ready, m_fe, m_pe, m_oe, (m_fe | m_pe | m_oe), 1'b0});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        rx_in = b;
        wait_clk(BITCLK);
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par, input bit low1,
                             input bit low2, input bit brk, input string req);
        logic [7:0] dm;
        int nb;
        logic p;
        bit efe, epe, st;
        quiet = 0;
        cur_req = req;
        nb = cfg_seven_bit ? 7 : 8;
        dm = cfg_seven_bit ? {1'b0, d[6:0]} : d;
        if (brk) dm = 8'h00;
        p = cfg_par_even ? ^dm : ~^dm;
        if (bad_par) p = ~p;
        if (brk) p = 1'b0;
        send_bit(1'b0);
        chk("R11", {31'd0, busy}, 32'd1);
        for (int i = 0; i < nb; i++) send_bit(cfg_msb_first ? dm[nb-1-i] : dm[i]);
        if (cfg_par_en) send_bit(p);
        send_bit((brk | low1) ? 1'b0 : 1'b1);
        if (cfg_two_stop) send_bit((brk | low2) ? 1'b0 : 1'b1);
        rx_in = 1'b1;
        wait_clk(3 * BITCLK);
        efe = brk | low1 | (cfg_two_stop & low2);
        epe = cfg_par_en && (brk ? !cfg_par_even : bad_par);
        if (brk)              st = cfg_brk_accept;
        else if (efe || epe)  st = cfg_err_accept;
        else                  st = 1'b1;
        if (st) begin
            m_oe    = m_oe | m_ready;
            m_fe    = m_fe | efe;
            m_pe    = m_pe | epe;
            m_data  = dm;
            m_ready = 1'b1;
        end
        quiet = 1;
    endtask

    task automatic do_read(input string req);
        quiet = 0;
        cur_req = req;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        m_ready = 0; m_fe = 0; m_pe = 0; m_oe = 0;
        chk(req, {27'd0, rx_ready, err_frame, err_parity, err_overrun, err_any}, 32'd0);
        quiet = 1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {rd_data, rx_ready, err_frame, err_parity, err_overrun, err_any, busy}, 32'd0);
        quiet = 1;
        wait_clk(10);

        // R3 8 bits LSB first, then MSB first
        send_char(8'h41, 0, 0, 0, 0, "R3");
        chk("R3", {24'd0, rd_data}, 32'h41);
        do_read("R8");
        cfg_msb_first = 1;
        send_char(8'h35, 0, 0, 0, 0, "R3");
        chk("R3", {24'd0, rd_data}, 32'h35);
        do_read("R8");
        // R3 seven-bit both orders, bit 7 dropped
        cfg_seven_bit = 1;
        send_char(8'h9A, 0, 0, 0, 0, "R3");
        chk("R3", {24'd0, rd_data}, 32'h1A);
        do_read("R8");
        cfg_msb_first = 0;
        send_char(8'hC5, 0, 0, 0, 0, "R3");
        chk("R3", {24'd0, rd_data}, 32'h45);
        do_read("R8");
        cfg_seven_bit = 0;

        // R4 parity good even and odd
        cfg_par_en = 1; cfg_par_even = 1; cfg_err_accept = 1;
        send_char(8'h3C, 0, 0, 0, 0, "R4");
        chk("R4", {31'd0, err_parity}, 32'd0);
        do_read("R8");
        cfg_par_even = 0;
        send_char(8'h07, 0, 0, 0, 0, "R4");
        chk("R4", {31'd0, err_parity}, 32'd0);
        do_read("R8");
        // R4/R9 bad parity accepted and flagged; R7 summary
        cfg_par_even = 1;
        send_char(8'h55, 1, 0, 0, 0, "R9");
        chk("R4", {30'd0, err_parity, rx_ready}, 32'd3);
        chk("R7", {31'd0, err_any}, 32'd1);
        do_read("R8");
        // R9 bad parity discarded
        cfg_err_accept = 0;
        send_char(8'h66, 1, 0, 0, 0, "R9");
        chk("R9", {31'd0, rx_ready}, 32'd0);
        cfg_par_en = 0;

        // R5 framing error accepted
        cfg_err_accept = 1;
        send_char(8'h81, 0, 1, 0, 0, "R5");
        chk("R5", {30'd0, err_frame, err_parity}, 32'd2);
        do_read("R8");
        // R12 two stop bits, good then second low
        cfg_two_stop = 1;
        send_char(8'hA7, 0, 0, 0, 0, "R12");
        chk("R12", {23'd0, rd_data, err_frame}, {23'd0, 8'hA7, 1'b0});
        do_read("R8");
        send_char(8'h5E, 0, 0, 1, 0, "R12");
        chk("R12", {31'd0, err_frame}, 32'd1);
        do_read("R8");
        cfg_two_stop = 0;

        // R6 overrun
        send_char(8'h11, 0, 0, 0, 0, "R6");
        send_char(8'h22, 0, 0, 0, 0, "R6");
        chk("R6", {22'd0, rd_data, err_overrun, err_any}, {22'd0, 8'h22, 1'b1, 1'b1});
        do_read("R8");

        // R10 break dropped, then stored
        cfg_brk_accept = 0;
        send_char(8'h00, 0, 0, 0, 1, "R10");
        chk("R10", {30'd0, rx_ready, err_frame}, 32'd0);
        cfg_brk_accept = 1; cfg_err_accept = 0;
        send_char(8'h00, 0, 0, 0, 1, "R10");
        chk("R10", {22'd0, rd_data, rx_ready, err_frame}, {22'd0, 8'h00, 1'b1, 1'b1});
        do_read("R8");

        // R2 short low pulse rejected
        quiet = 0;
        cur_req = "R2";
        rx_in = 1'b0;
        wait_clk(3 * DIV);
        rx_in = 1'b1;
        wait_clk(20 * DIV);
        chk("R2", {30'd0, busy, rx_ready}, 32'd0);
        quiet = 1;
        wait_clk(20);

        finish_run();
    end
endmodule